// File: doc/BRIEF.md
# Clock Failure Alarm Monitor

This block watches six clock-health indications of a clock-distribution node and turns their failures into host-facing events. Each indication is a level signal that is high while its clock is bad. The block brings every indication into its own clock domain through a two-flop synchroniser. It reacts only when an indication goes from good to failed.

Every such transition sets a sticky bit in a history bitmask. The host can read this mask at any time and clears bits by writing ones. An alarm is forwarded to the host only if its own enable bit in a mask register is set, and all enables start cleared. When several enabled alarms start in the same cycle, they come out one per cycle with the lowest index first. The alarm event carries the source index as its code.

Once any source has failed, a poll timer runs with a period of POLL_MS milliseconds, derived from the CLK_HZ parameter (40 ms by default). At each poll, the block reports every failed source that has become good again on a separate recovery event. After a source recovers, it is re-armed for its next failure.

Top module: `clkmon_alarm_top`

## Requirements
- R1: The source index, used for the fail_in bit, the history bit, the mask bit and the alarm code, is assigned as follows: 0 = backplane right clock lost, 1 = backplane left clock lost, 2 = local bus clock lost, 3 = local bus clockfail signal asserted, 4 = external reference lost, 5 = PLL out of lock. Each fail_in bit passes through two synchroniser flops.
- R2: A good-to-failed transition of an enabled source produces exactly one alarm_vld pulse with alarm_code equal to its index. While a source is held failed, no further alarm follows. alarm_code is always below 6 when alarm_vld is high.
- R3: mask_we loads mask_wdata into the enable mask, where bit i = 1 enables source i. A failure of a source whose bit is 0 produces no alarm.
- R4: After reset the history is zero, all enable bits are zero and neither alarm_vld nor recov_vld is high.
- R5: Every good-to-failed transition sets hist_q bit i, whether or not the source is enabled. A history bit never falls without a clear.
- R6: hist_clr_we with hist_clr_data clears the history bits written as 1. A clear that lands in the same cycle as a new failure of that source leaves the bit set.
- R7: Enabled failures starting in the same cycle are reported in consecutive cycles in ascending index order, one alarm per cycle.
- R8: While any source is marked failed, a poll fires every CLK_HZ/1000*POLL_MS cycles. At a poll, recov_vld pulses for one cycle with recov_bits holding the failed sources that are now good. recov_bits is zero when recov_vld is low, and there is no recovery event if no source recovered.
- R9: A source that is still failed is never reported as recovered. Sources recover individually. A recovered source raises a new alarm on its next failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_in | input | 6 | Asynchronous failure levels, one per source (1 = failed) |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 6 | New enable mask |
| hist_clr_we | input | 1 | Write strobe for the history clear |
| hist_clr_data | input | 6 | History bits to clear (1 = clear) |
| hist_q | output | 6 | Sticky failure history |
| alarm_vld | output | 1 | One-cycle alarm event |
| alarm_code | output | 3 | Source index of the alarm |
| recov_vld | output | 1 | One-cycle clock-recovered event |
| recov_bits | output | 6 | Sources found recovered at this poll |

## Verification
The assertions check the following on every cycle:
- the legal range of alarm codes;
- the rule that history bits only fall under a clear;
- the tie between recovery events and poll ticks;
- that a recovered source was marked failed the cycle before;
- the quiet state right after reset.

Only the bench scenarios can show the rest:
- the ordering of simultaneous alarms;
- the effect of masking and its reset value;
- the single alarm for a held failure;
- the collision of a clear with a fresh failure;
- partial recovery;
- re-arming after recovery.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    localparam int NSRC   = 6;
    localparam int CODE_W = $clog2(NSRC);

    typedef logic [NSRC-1:0]   src_vec_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum code_t {
        SRC_BP_RIGHT  = 3'd0,
        SRC_BP_LEFT   = 3'd1,
        SRC_LB_CLK    = 3'd2,
        SRC_LB_CFAIL  = 3'd3,
        SRC_EXT_REF   = 3'd4,
        SRC_PLL_LOCK  = 3'd5
    } src_e;

    typedef struct packed {
        logic  vld;
        code_t code;
    } alarm_evt_t;

    typedef struct packed {
        logic     vld;
        src_vec_t bits;
    } recov_evt_t;

    // isolate the lowest set bit
    function automatic src_vec_t lowest_bit(src_vec_t v);
        return v & (~v + src_vec_t'(1));
    endfunction

    // index of a one-hot vector
    function automatic code_t bit_index(src_vec_t onehot);
        code_t idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (onehot[i]) idx = code_t'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clkmon_poll_timer.sv
module clkmon_poll_timer #(
    parameter int PERIOD = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/clkmon_alarm_queue.sv
module clkmon_alarm_queue
    import clkmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   new_req,
    output alarm_evt_t evt
);
    src_vec_t pend;
    src_vec_t grant;

    assign grant = lowest_bit(pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            evt  <= '0;
        end else begin
            pend     <= (pend & ~grant) | new_req;
            evt.vld  <= |pend;
            evt.code <= bit_index(grant);
        end
    end
endmodule

// File: rtl/clkmon_recovery.sv
module clkmon_recovery
    import clkmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   rise,
    input  src_vec_t   level,
    input  logic       tick,
    output src_vec_t   failed_q,
    output recov_evt_t evt
);
    src_vec_t rec;

    assign rec = tick ? (failed_q & ~level) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            failed_q <= '0;
            evt      <= '0;
        end else begin
            failed_q <= (failed_q & ~rec) | rise;
            evt.vld  <= |rec;
            evt.bits <= rec;
        end
    end
endmodule

// File: rtl/clkmon_alarm_top.sv
module clkmon_alarm_top
    import clkmon_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int POLL_MS = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  fail_in,
    input  logic        mask_we,
    input  logic [5:0]  mask_wdata,
    input  logic        hist_clr_we,
    input  logic [5:0]  hist_clr_data,
    output logic [5:0]  hist_q,
    output logic        alarm_vld,
    output logic [2:0]  alarm_code,
    output logic        recov_vld,
    output logic [5:0]  recov_bits
);
    localparam int POLL_CYCLES = (CLK_HZ / 1000) * POLL_MS;

    src_vec_t   lvl, lvl_d, rise, mask_q, hist_r, clr_vec, failed_q;
    logic       poll_tick;
    alarm_evt_t a_evt;
    recov_evt_t r_evt;

    clkmon_sync #(.W(NSRC), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(fail_in), .q(lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= '0;
        else     lvl_d <= lvl;
    end
    assign rise = lvl & ~lvl_d;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    assign clr_vec = hist_clr_we ? hist_clr_data : '0;
    always_ff @(posedge clk) begin
        if (rst) hist_r <= '0;
        else     hist_r <= (hist_r & ~clr_vec) | rise;
    end

    clkmon_alarm_queue u_queue (
        .clk(clk), .rst(rst), .new_req(rise & mask_q), .evt(a_evt)
    );

    clkmon_poll_timer #(.PERIOD(POLL_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .run(|failed_q), .tick(poll_tick)
    );

    clkmon_recovery u_recov (
        .clk(clk), .rst(rst), .rise(rise), .level(lvl),
        .tick(poll_tick), .failed_q(failed_q), .evt(r_evt)
    );

    assign hist_q     = hist_r;
    assign alarm_vld  = a_evt.vld;
    assign alarm_code = a_evt.code;
    assign recov_vld  = r_evt.vld;
    assign recov_bits = r_evt.bits;
endmodule

// File: rtl/clkmon_alarm_chk.sv
module clkmon_alarm_chk (
    input logic       clk,
    input logic       rst,
    input logic       hist_clr_we,
    input logic [5:0] hist_q,
    input logic       alarm_vld,
    input logic [2:0] alarm_code,
    input logic       recov_vld,
    input logic [5:0] recov_bits,
    input logic       poll_tick,
    input logic [5:0] failed_q
);
    // R4
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hist_q == 6'd0 && !alarm_vld && !recov_vld));

    // R2
    alarm_code_range_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_vld |-> (alarm_code < 3'd6));

    // R5
    hist_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !hist_clr_we |=> ((hist_q & $past(hist_q)) == $past(hist_q)));

    // R8
    recov_on_poll_chk: assert property (@(posedge clk) disable iff (rst)
        recov_vld |-> $past(poll_tick));

    // R8
    recov_bits_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (recov_vld == (recov_bits != 6'd0)));

    // R9
    recov_was_failed_chk: assert property (@(posedge clk) disable iff (rst)
        recov_vld |-> ((recov_bits & ~$past(failed_q)) == 6'd0));
endmodule

bind clkmon_alarm_top clkmon_alarm_chk u_chk (
    .clk(clk), .rst(rst), .hist_clr_we(hist_clr_we), .hist_q(hist_q),
    .alarm_vld(alarm_vld), .alarm_code(alarm_code), .recov_vld(recov_vld),
    .recov_bits(recov_bits), .poll_tick(poll_tick), .failed_q(failed_q)
);

// File: tb/tb_clkmon_alarm_top.sv
`timescale 1ns/1ps
module tb_clkmon_alarm_top;
    localparam int CLK_HZ  = 100_000;
    localparam int POLL_MS = 1;
    localparam int POLL    = (CLK_HZ / 1000) * POLL_MS;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] fail_in, mask_wdata, hist_clr_data;
    logic       mask_we, hist_clr_we;
    logic [5:0] hist_q, recov_bits;
    logic       alarm_vld, recov_vld;
    logic [2:0] alarm_code;

    int total = 0;
    int fails = 0;
    int alarm_q[$];
    logic [5:0] rec_q[$];

    always #4 clk = ~clk;

    clkmon_alarm_top #(.CLK_HZ(CLK_HZ), .POLL_MS(POLL_MS)) dut (
        .clk(clk), .rst(rst), .fail_in(fail_in), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .hist_clr_we(hist_clr_we),
        .hist_clr_data(hist_clr_data), .hist_q(hist_q),
        .alarm_vld(alarm_vld), .alarm_code(alarm_code),
        .recov_vld(recov_vld), .recov_bits(recov_bits)
    );

    always @(negedge clk) begin
        if (!rst && alarm_vld) alarm_q.push_back(int'(alarm_code));
        if (!rst && recov_vld) rec_q.push_back(recov_bits);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mask(input logic [5:0] m);
        mask_we = 1'b1; mask_wdata = m;
        cyc(1);
        mask_we = 1'b0;
    endtask

    task automatic clear_hist(input logic [5:0] c);
        hist_clr_we = 1'b1; hist_clr_data = c;
        cyc(1);
        hist_clr_we = 1'b0;
    endtask

    // expected alarms: enabled new failures, ascending index
    task automatic check_alarms(input logic [5:0] exp_bits, input string req);
        int n = 0;
        for (int i = 0; i < 6; i++) begin
            if (exp_bits[i]) begin
                if (n < alarm_q.size())
                    chk(alarm_q[n] == i, req, "alarm order", alarm_q[n], i);
                n++;
            end
        end
        chk(alarm_q.size() == n, req, "alarm count", alarm_q.size(), n);
        alarm_q.delete();
    endtask

    task automatic check_recov(input logic [5:0] exp_bits, input string req);
        chk(rec_q.size() == 1, req, "recovery event count", rec_q.size(), 1);
        if (rec_q.size() > 0)
            chk(rec_q[0] == exp_bits, req, "recovered bits",
                int'(rec_q[0]), int'(exp_bits));
        rec_q.delete();
    endtask

    initial begin
        #(8 * 150000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [5:0] m, p;
        void'($urandom(32'd4242));
        rst = 1'b1; fail_in = '0; mask_we = 0; mask_wdata = '0;
        hist_clr_we = 0; hist_clr_data = '0;
        cyc(5);
        rst = 1'b0;
        cyc(1);

        // R4 reset state
        chk(hist_q == 6'd0, "R4", "history after reset", int'(hist_q), 0);
        chk(!alarm_vld && !recov_vld, "R4", "events after reset",
            int'({alarm_vld, recov_vld}), 0);

        // R4/R3 masks reset disabled; R5 history set regardless
        fail_in = 6'b000001;
        cyc(10);
        check_alarms(6'b000000, "R4");
        chk(hist_q == 6'b000001, "R5", "history of masked failure", int'(hist_q), 1);
        fail_in = '0;
        cyc(POLL + 10);
        check_recov(6'b000001, "R8");
        clear_hist(6'b111111);
        cyc(1);
        chk(hist_q == 6'd0, "R6", "history after clear", int'(hist_q), 0);

        // R2 held failure gives one alarm; R9 no recovery while failed
        write_mask(6'b111111);
        fail_in = 6'b000100;
        cyc(3 * POLL + 5);
        check_alarms(6'b000100, "R2");
        chk(rec_q.size() == 0, "R9", "recovery while failed", rec_q.size(), 0);

        // R1 index 0 (backplane right) alarm while bit 2 still failed
        fail_in = 6'b000101;
        cyc(10);
        check_alarms(6'b000001, "R1");
        fail_in = 6'b000100;
        cyc(POLL + 10);
        check_recov(6'b000001, "R9");
        fail_in = 6'b000000;
        cyc(POLL + 10);
        check_recov(6'b000100, "R9");

        // R9 re-arm after recovery
        fail_in = 6'b000001;
        cyc(10);
        check_alarms(6'b000001, "R9");
        fail_in = '0;
        cyc(POLL + 10);
        rec_q.delete();

        // R6 clear colliding with a fresh failure of bit 3; plain clear of bit 0
        chk(hist_q == 6'b000101, "R5", "accumulated history", int'(hist_q), 5);
        fail_in = 6'b001000;      // bit 3 sync: edge1, edge2; history set on edge3
        cyc(2);
        hist_clr_we = 1'b1; hist_clr_data = 6'b001001;
        cyc(1);
        hist_clr_we = 1'b0;
        cyc(1);
        chk(hist_q[3] == 1'b1, "R6", "set wins over clear", int'(hist_q[3]), 1);
        chk(hist_q[0] == 1'b0, "R6", "plain clear", int'(hist_q[0]), 0);
        fail_in = '0;
        cyc(POLL + 10);
        alarm_q.delete(); rec_q.delete();

        // R7 simultaneous failures in ascending order on consecutive cycles
        fail_in = 6'b101010;
        cyc(12);
        check_alarms(6'b101010, "R7");
        fail_in = '0;
        cyc(POLL + 10);
        check_recov(6'b101010, "R8");

        // random masks and patterns: R3 R5 R7 R8
        for (int it = 0; it < 20; it++) begin
            m = 6'($urandom);
            p = 6'($urandom);
            if (p == 6'd0) p = 6'b010000;
            clear_hist(6'b111111);
            write_mask(m);
            fail_in = p;
            cyc(12);
            check_alarms(p & m, "R3");
            chk(hist_q == p, "R5", "random history", int'(hist_q), int'(p));
            fail_in = '0;
            cyc(POLL + 10);
            check_recov(p, "R8");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule